// File: doc/BRIEF.md
# Stop mode wake-up controller

This block sequences a small 8-bit microcontroller into and out of its deepest low-power state. The CPU raises a stop request. The request is accepted only while the on-chip network controller reports that it is asleep. On acceptance the block spends one entry cycle. In that cycle it strobes the interrupt-mask clear and the watchdog clear, and it asserts hold on the CPU and freeze or disable levels on the timer, serial port and converter. It then turns the oscillator off.

While stopped, the block watches four wake sources: a network controller interrupt, a wired-OR interrupt, an external interrupt line and a reset request. Any of them turns the oscillator back on. The block records the cause, with reset winning, and holds the CPU for a stabilisation count of 16 or 4064 cycles. The count length is chosen by a static select that is sampled when the stop is accepted. During the count the slow-clock mode is forced off. At the end the block releases the CPU for one cycle. In that cycle it raises a done pulse and presents the vector address for the cause. If the cause is an interrupt, it also raises a stacking go pulse, so that interrupt stacking happens only after the exit.

The state machine has five states:

| State | Meaning | Transitions |
|---|---|---|
| RUN | Normal operation | Goes to ENTER on an accepted stop (request high while sleep is reported). |
| ENTER | One cycle, oscillator still running | Always goes to STOPPED. |
| STOPPED | Oscillator off | Goes to RESTART on any wake. |
| RESTART | Stabilisation count | A reset request restarts the count and stays in RESTART. Reaching the limit goes to RELEASE. |
| RELEASE | One cycle, CPU let go | Always goes to RUN. |

Top module: `stop_wake_ctrl`

## Requirements
- R1: With `net_sleep` low, `stop_req` has no effect: `osc_en` stays 1, `cpu_hold` stays 0 and `tmr_freeze` stays 0.
- R2: An accepted stop is seen at the next clock edge. In the following cycle `irq_mask_clr` and `wdog_clr` are 1 for exactly that cycle and `osc_en` is still 1. From the cycle after that, `osc_en` is 0.
- R3: From the entry cycle until release, `cpu_hold`, `tmr_freeze`, `sci_freeze` and `adc_off` are all 1.
- R4: While stopped with no wake source active, `osc_en` stays 0 indefinitely. A wake source sampled high at an edge makes `osc_en` 1 right after that edge.
- R5: `done` rises exactly N edges after the edge that captured the wake. N is 16 when `dly_long` was 0 at stop acceptance and 4064 when it was 1. Changes to `dly_long` after acceptance do not change N.
- R6: `slow_clr` is 1 throughout the stabilisation count.
- R7: `wake_cause` encoding: 0 = network interrupt, 1 = wired-OR interrupt, 2 = external interrupt, 3 = reset. Priority when several are active together is reset, then network, then wired-OR, then external.
- R8: `vec_addr` is 0x3FFE for a reset cause and 0x3FFA for an interrupt cause. It is valid in the `done` cycle and stays unchanged until the next wake.
- R9: `done` lasts one cycle and coincides with the first cycle of `cpu_hold` low. `irq_stack_go` is 1 in that cycle only when the cause is an interrupt.
- R10: A reset request during the stabilisation count restarts the count from its capture edge and sets the cause to reset. Interrupts during the count are ignored.
- R11: After block reset: `osc_en`=1, `cpu_hold`=0, all freezes 0, `done`=0, `wake_cause`=3, `vec_addr`=0x3FFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req | input | 1 | Stop request from the CPU |
| net_sleep | input | 1 | Network controller is asleep |
| dly_long | input | 1 | Stabilisation select: 0 = short count, 1 = long count |
| wake_net | input | 1 | Network controller interrupt |
| wake_wor | input | 1 | Wired-OR interrupt |
| wake_ext | input | 1 | External interrupt line |
| wake_rst | input | 1 | Reset request from pin or power-on logic |
| osc_en | output | 1 | Oscillator enable |
| cpu_hold | output | 1 | Holds the CPU |
| irq_mask_clr | output | 1 | Entry strobe that clears the interrupt mask bit |
| wdog_clr | output | 1 | Entry strobe that resets the watchdog counter |
| tmr_freeze | output | 1 | Stops the timer counting |
| sci_freeze | output | 1 | Halts serial activity |
| adc_off | output | 1 | Disables the converter |
| slow_clr | output | 1 | Forces nominal clock speed during the count |
| done | output | 1 | One-cycle release pulse |
| irq_stack_go | output | 1 | Allows stacking of the waking interrupt |
| wake_cause | output | 2 | Recorded wake cause |
| vec_addr | output | 16 | Vector address for the cause |

## Verification
Entry strobes are due one edge after the request is sampled, and the oscillator drops one edge later. The oscillator returns and `slow_clr` is high one edge after a wake is sampled. `done` is due exactly 16 or 4064 edges after the capture edge. The driver records the cycle-counter value just after the capture edge and pushes an expected item holding that value plus N, together with the cause and the vector. The monitor samples on falling edges, pops an item whenever `done` is seen, and compares the cycle number, cause, vector, hold and stacking go. A reset during the count makes the driver push a fresh item from the new capture edge.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_ENTER   = 3'd1,
        ST_STOPPED = 3'd2,
        ST_RESTART = 3'd3,
        ST_RELEASE = 3'd4
    } swc_state_t;

    typedef enum logic [1:0] {
        WK_NET = 2'd0,
        WK_WOR = 2'd1,
        WK_EXT = 2'd2,
        WK_RST = 2'd3
    } wake_cause_t;
endpackage

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
    import swc_pkg::*;
(
    input  logic        wake_net,
    input  logic        wake_wor,
    input  logic        wake_ext,
    input  logic        wake_rst,
    output logic        any_wake,
    output wake_cause_t cause
);
    always_comb begin
        any_wake = wake_net | wake_wor | wake_ext | wake_rst;
        if (wake_rst)      cause = WK_RST;
        else if (wake_net) cause = WK_NET;
        else if (wake_wor) cause = WK_WOR;
        else               cause = WK_EXT;
    end
endmodule

// File: rtl/swc_delay_cnt.sv
module swc_delay_cnt #(
    parameter int SHORT_CYC = 16,
    parameter int LONG_CYC  = 4064,
    localparam int CW = $clog2(LONG_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic sel_long,
    output logic hit
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = sel_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
        hit   = run && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (run && !hit)    cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LONG_CYC - 1)); // R5
    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/swc_vector_reg.sv
module swc_vector_reg
    import swc_pkg::*;
#(
    parameter logic [15:0] VEC_RST = 16'h3FFE,
    parameter logic [15:0] VEC_IRQ = 16'h3FFA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  wake_cause_t cause_in,
    output wake_cause_t cause_q,
    output logic [15:0] vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cause_q <= WK_RST;
        else if (load) cause_q <= cause_in;
    end

    always_comb vec = (cause_q == WK_RST) ? VEC_RST : VEC_IRQ;

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cause_q)); // R8
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int          SHORT_CYC = 16,
    parameter int          LONG_CYC  = 4064,
    parameter logic [15:0] VEC_RST   = 16'h3FFE,
    parameter logic [15:0] VEC_IRQ   = 16'h3FFA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_req,
    input  logic        net_sleep,
    input  logic        dly_long,
    input  logic        wake_net,
    input  logic        wake_wor,
    input  logic        wake_ext,
    input  logic        wake_rst,
    output logic        osc_en,
    output logic        cpu_hold,
    output logic        irq_mask_clr,
    output logic        wdog_clr,
    output logic        tmr_freeze,
    output logic        sci_freeze,
    output logic        adc_off,
    output logic        slow_clr,
    output logic        done,
    output logic        irq_stack_go,
    output logic [1:0]  wake_cause,
    output logic [15:0] vec_addr
);
    swc_state_t  state_q, state_d;
    logic        accept;
    logic        any_wake;
    wake_cause_t arb_cause;
    wake_cause_t cause_q;
    logic        dly_sel_q;
    logic        cnt_clr, cnt_run, cnt_hit;
    logic        cause_load;

    swc_wake_arb u_arb (
        .wake_net (wake_net),
        .wake_wor (wake_wor),
        .wake_ext (wake_ext),
        .wake_rst (wake_rst),
        .any_wake (any_wake),
        .cause    (arb_cause)
    );

    swc_delay_cnt #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .run      (cnt_run),
        .sel_long (dly_sel_q),
        .hit      (cnt_hit)
    );

    swc_vector_reg #(.VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cause_load),
        .cause_in (arb_cause),
        .cause_q  (cause_q),
        .vec      (vec_addr)
    );

    // Stop entry is honoured only while the network controller sleeps.
    always_comb begin
        accept     = (state_q == ST_RUN) && stop_req && net_sleep;
        cnt_clr    = (state_q == ST_STOPPED) || ((state_q == ST_RESTART) && wake_rst);
        cnt_run    = (state_q == ST_RESTART) && !wake_rst;
        cause_load = ((state_q == ST_STOPPED) && any_wake) ||
                     ((state_q == ST_RESTART) && wake_rst);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (accept)   state_d = ST_ENTER;
            ST_ENTER:                 state_d = ST_STOPPED;
            ST_STOPPED: if (any_wake) state_d = ST_RESTART;
            ST_RESTART: if (!wake_rst && cnt_hit) state_d = ST_RELEASE;
            ST_RELEASE:               state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            dly_sel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) dly_sel_q <= dly_long;
        end
    end

    always_comb begin
        osc_en       = 1'b1;
        cpu_hold     = 1'b0;
        irq_mask_clr = 1'b0;
        wdog_clr     = 1'b0;
        slow_clr     = 1'b0;
        done         = 1'b0;
        irq_stack_go = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_ENTER: begin
                cpu_hold     = 1'b1;
                irq_mask_clr = 1'b1;
                wdog_clr     = 1'b1;
            end
            ST_STOPPED: begin
                osc_en   = 1'b0;
                cpu_hold = 1'b1;
            end
            ST_RESTART: begin
                cpu_hold = 1'b1;
                slow_clr = 1'b1;
            end
            ST_RELEASE: begin
                done         = 1'b1;
                irq_stack_go = (cause_q != WK_RST);
            end
            default: ;
        endcase
        tmr_freeze = cpu_hold;
        sci_freeze = cpu_hold;
        adc_off    = cpu_hold;
        wake_cause = cause_q;
    end

    AST_ENTRY_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_freeze) |-> $past(stop_req && net_sleep)); // R1
    AST_OSC_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (cpu_hold && adc_off && sci_freeze)); // R3
    AST_WAKE_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && any_wake) |=> osc_en); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_HOLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(cpu_hold)); // R9
    AST_RST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wake_cause == 2'd3) |-> (vec_addr == VEC_RST && !irq_stack_go)); // R8
endmodule

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, net_sleep = 0, dly_long = 0;
    logic wake_net = 0, wake_wor = 0, wake_ext = 0, wake_rst = 0;
    logic osc_en, cpu_hold, irq_mask_clr, wdog_clr, tmr_freeze, sci_freeze, adc_off;
    logic slow_clr, done, irq_stack_go;
    logic [1:0]  wake_cause;
    logic [15:0] vec_addr;

    stop_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .net_sleep(net_sleep),
        .dly_long(dly_long), .wake_net(wake_net), .wake_wor(wake_wor),
        .wake_ext(wake_ext), .wake_rst(wake_rst), .osc_en(osc_en),
        .cpu_hold(cpu_hold), .irq_mask_clr(irq_mask_clr), .wdog_clr(wdog_clr),
        .tmr_freeze(tmr_freeze), .sci_freeze(sci_freeze), .adc_off(adc_off),
        .slow_clr(slow_clr), .done(done), .irq_stack_go(irq_stack_go),
        .wake_cause(wake_cause), .vec_addr(vec_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    typedef struct packed {
        logic [31:0] due;
        logic [1:0]  cause;
        logic [15:0] vec;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Monitor: pops the expected release on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(0, "R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.due, "R5 R10 release cycle", cyc, e.due);
                chk(wake_cause == e.cause, "R7 cause", {30'd0, wake_cause}, {30'd0, e.cause});
                chk(vec_addr == e.vec, "R8 vector", {16'd0, vec_addr}, {16'd0, e.vec});
                chk(cpu_hold == 1'b0, "R9 hold low at done", {31'd0, cpu_hold}, 32'd0);
                chk(irq_stack_go == (e.cause != 2'd3), "R9 stack go", {31'd0, irq_stack_go},
                    {31'd0, (e.cause != 2'd3)});
            end
        end
    end

    task automatic enter_stop(input bit lng);
        @(negedge clk);
        stop_req = 1; net_sleep = 1; dly_long = lng;
        @(posedge clk);
        @(negedge clk);
        stop_req = 0; dly_long = ~lng;   // later changes must not matter (R5)
        chk(irq_mask_clr && wdog_clr, "R2 entry strobes", {30'd0, irq_mask_clr, wdog_clr}, 32'd3);
        chk(osc_en == 1'b1, "R2 osc on in entry cycle", {31'd0, osc_en}, 32'd1);
        chk(cpu_hold == 1'b1, "R3 hold at entry", {31'd0, cpu_hold}, 32'd1);
        @(negedge clk);
        chk(osc_en == 1'b0, "R2 osc off", {31'd0, osc_en}, 32'd0);
        chk(!irq_mask_clr && !wdog_clr, "R2 strobes one cycle", {30'd0, irq_mask_clr, wdog_clr}, 32'd0);
        chk(tmr_freeze && sci_freeze && adc_off && cpu_hold, "R3 freezes",
            {28'd0, tmr_freeze, sci_freeze, adc_off, cpu_hold}, 32'hF);
    endtask

    task automatic wake(input bit n, input bit w, input bit e, input bit r,
                        input bit push, input int nc, input logic [1:0] cs);
        int unsigned cap;
        @(negedge clk);
        wake_net = n; wake_wor = w; wake_ext = e; wake_rst = r;
        @(posedge clk);
        #1 cap = cyc;
        if (push) sb.push_back('{due: cap + nc, cause: cs,
                                 vec: (cs == 2'd3) ? 16'h3FFE : 16'h3FFA});
        @(negedge clk);
        wake_net = 0; wake_wor = 0; wake_ext = 0; wake_rst = 0;
        chk(osc_en == 1'b1, "R4 osc back on", {31'd0, osc_en}, 32'd1);
        chk(slow_clr == 1'b1, "R6 slow clear", {31'd0, slow_clr}, 32'd1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && sb.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
        chk(sb.size() == 0, "R5 release arrived", sb.size(), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(osc_en && !cpu_hold && !tmr_freeze && !done, "R11 reset outputs",
            {28'd0, osc_en, cpu_hold, tmr_freeze, done}, 32'h8);
        chk(wake_cause == 2'd3 && vec_addr == 16'h3FFE, "R11 reset cause/vector",
            {14'd0, wake_cause, vec_addr}, {14'd0, 2'd3, 16'h3FFE});

        // R1: refused without network sleep
        stop_req = 1; net_sleep = 0;
        repeat (3) @(negedge clk);
        chk(osc_en && !cpu_hold && !tmr_freeze, "R1 request ignored",
            {29'd0, osc_en, cpu_hold, tmr_freeze}, 32'h4);
        stop_req = 0;

        // Short delay, network wake
        enter_stop(0);
        wake(1, 0, 0, 0, 1, 16, 2'd0);
        wait_done();
        repeat (5) @(negedge clk);
        chk(vec_addr == 16'h3FFA, "R8 vector held", {16'd0, vec_addr}, 32'h3FFA);

        // Long delay, sampled at entry; idle stop; wired-OR beats external
        enter_stop(1);
        repeat (50) @(negedge clk);
        chk(osc_en == 1'b0, "R4 stays stopped", {31'd0, osc_en}, 32'd0);
        wake(0, 1, 1, 0, 1, 4064, 2'd1);
        wait_done();

        // External alone
        enter_stop(0);
        wake(0, 0, 1, 0, 1, 16, 2'd2);
        wait_done();

        // Reset beats interrupts in the same cycle
        enter_stop(0);
        wake(1, 0, 1, 1, 1, 16, 2'd3);
        wait_done();
        repeat (5) @(negedge clk);
        chk(vec_addr == 16'h3FFE, "R8 reset vector held", {16'd0, vec_addr}, 32'h3FFE);

        // R10: reset during count restarts it; interrupt during count ignored
        enter_stop(0);
        wake(1, 0, 0, 0, 0, 16, 2'd0);
        repeat (4) @(negedge clk);
        wake_ext = 1;
        @(negedge clk);
        wake_ext = 0;
        chk(wake_cause == 2'd0, "R10 interrupt ignored in count", {30'd0, wake_cause}, 32'd0);
        @(negedge clk);
        wake(0, 0, 0, 1, 1, 16, 2'd3);
        wait_done();

        finish_run();
    end
endmodule